// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block sits between a register bus and the mode logic of an on-chip flash array that is split into two areas: a lower area (0x000000 to 0x03FFFF) and an upper area (0x040000 to 0x07FFFF). Software asks for a program or erase operation on an area by setting request bits in that area's control register. The controller enters the requested mode only when every protection layer allows it.

Protection has three layers. Each area has its own write-enable bit, and that bit gates both program and erase. Per-block erase-enable bits gate erase only. A single emulation-lock flag refuses every operation in both areas. If protection becomes active while a mode is running, the controller returns the area to idle and latches a sticky violation flag. For each area, the mode and a rejected flag can be read on status outputs and through a status register.

The register map, with byte-wide data, is:
- 0 and 1: area control registers for the lower and upper area. Bit 0 is write-enable, bit 1 is program request, bit 2 is erase request.
- 2: erase enables for blocks 0..7, which lie in the lower area.
- 3: erase enables for blocks 8..15, which lie in the upper area.
- 4: bit 0 is the emulation lock.
- 5: read-only status. Bits 1:0 are the lower-area mode, bits 3:2 the upper-area mode, bit 4 is lower rejected, bit 5 is upper rejected, bit 6 is violation.

Modes are encoded as idle = 0, program = 1, erase = 2.

Top module: `flash_prot_ctrl`

## Requirements
- R1: After reset, every register reads 0x00, both areas are idle, and the rejected and violation flags are 0.
- R2: A write to addresses 0 to 4 appears on regRdata in the cycle after the write strobe. Writes to address 5 have no effect.
- R3: A program request (control bit 1) in an area with write-enable (bit 0) set and the emulation lock clear puts that area in program mode (1) one cycle after the register holds the request.
- R4: With an area's write-enable at 0, neither a program request nor an erase request leaves idle, and the area's rejected flag becomes 1.
- R5: An erase request (control bit 2) is granted only when the area's write-enable is 1, the emulation lock is 0, and at least one erase-enable bit of that area's blocks is 1. When both block registers are 0x00, every erase is refused.
- R6: Block erase-enable bits never block programming.
- R7: With the emulation lock at 1, both areas stay idle for every request and report rejected.
- R8: Program and erase requested together in one area leave that area idle and set its rejected flag.
- R9: If a running mode loses its permission, the area is idle on the next clock and status bit 6 becomes 1. That bit stays set until reset.
- R10: A granted request clears the area's rejected flag. With no request pending, the area is idle and the flag holds its value.
- R11: The two areas are decided independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for writes and reads |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr (combinational) |
| areaMode | output | 4 | Mode per area: [1:0] lower, [3:2] upper |
| areaReject | output | 2 | Last request rejected, one bit per area |
| protViol | output | 1 | Sticky protection violation |

## Verification
The assertions take for granted that inputs change only away from the rising clock edge and that regAddr is below 6 whenever regWe is high. The bench drives every input on the falling edge. Its random phase draws addresses only from 0 to 5. In that phase, control-register data is restricted to three bits and the emulation flag is held low most of the time, so that program and erase grants, revocations and conflicting requests all occur often.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;
  localparam int AREAS     = 2;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int CTRL_BITS = 3;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_PROG  = 2'd1,
    MODE_ERASE = 2'd2
  } mode_e;

  typedef struct packed {
    logic [AREAS-1:0]  ctrlWr;
    logic [AREAS-1:0]  blkWr;
    logic              emulWr;
    logic [DATA_W-1:0] data;
  } strobe_t;

  typedef struct packed {
    logic [AREAS-1:0] wen;
    logic [AREAS-1:0] progReq;
    logic [AREAS-1:0] eraseReq;
    logic [AREAS-1:0] blkAny;
    logic             emul;
  } perm_t;
endpackage

// File: rtl/fp_datapath.sv
module fp_datapath
  import flash_prot_pkg::*;
#(
  parameter int STAT_W = 3 * AREAS + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [STAT_W-1:0] statVec,
  output perm_t             perm,
  output logic [DATA_W-1:0] regRdata
);
  localparam int ADDR_EMUL = 2 * AREAS;
  localparam int ADDR_STAT = 2 * AREAS + 1;

  logic [CTRL_BITS-1:0] ctrlQ [AREAS];
  logic [DATA_W-1:0]    blkQ  [AREAS];
  logic                 emulQ;

  for (genvar a = 0; a < AREAS; a++) begin : g_area
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrlQ[a] <= '0;
        blkQ[a]  <= '0;
      end else begin
        if (strb.ctrlWr[a]) ctrlQ[a] <= strb.data[CTRL_BITS-1:0];
        if (strb.blkWr[a])  blkQ[a]  <= strb.data;
      end
    end
    assign perm.wen[a]      = ctrlQ[a][0];
    assign perm.progReq[a]  = ctrlQ[a][1];
    assign perm.eraseReq[a] = ctrlQ[a][2];
    assign perm.blkAny[a]   = |blkQ[a];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            emulQ <= 1'b0;
    else if (strb.emulWr) emulQ <= strb.data[0];
  end
  assign perm.emul = emulQ;

  always_comb begin
    regRdata = '0;
    for (int a = 0; a < AREAS; a++) begin
      if (regAddr == ADDR_W'(a))         regRdata = DATA_W'(ctrlQ[a]);
      if (regAddr == ADDR_W'(AREAS + a)) regRdata = blkQ[a];
    end
    if (regAddr == ADDR_W'(ADDR_EMUL)) regRdata = DATA_W'(emulQ);
    if (regAddr == ADDR_W'(ADDR_STAT)) regRdata = DATA_W'(statVec);
  end

  AST_RESET_CLEAN: assert property (@(posedge clk) $rose(rstN) |-> (emulQ == 1'b0)) // R1
    else $error("emulation flag not clear after reset");
  AST_EMUL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.emulWr) |-> $stable(emulQ)) // R2
    else $error("emulation flag changed without a write");
endmodule

// File: rtl/fp_control.sv
module fp_control
  import flash_prot_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  input  perm_t                perm,
  output strobe_t              strb,
  output logic [2*AREAS-1:0]   areaMode,
  output logic [AREAS-1:0]     areaReject,
  output logic                 protViol
);
  localparam int ADDR_EMUL = 2 * AREAS;

  logic [AREAS-1:0] violHit;

  always_comb begin
    strb        = '0;
    strb.data   = regWdata;
    strb.emulWr = regWe && (regAddr == ADDR_W'(ADDR_EMUL));
    for (int a = 0; a < AREAS; a++) begin
      strb.ctrlWr[a] = regWe && (regAddr == ADDR_W'(a));
      strb.blkWr[a]  = regWe && (regAddr == ADDR_W'(AREAS + a));
    end
  end

  for (genvar a = 0; a < AREAS; a++) begin : g_fsm
    mode_e modeQ, modeD;
    logic  rejQ, rejD, progOk, eraseOk;

    assign progOk  = perm.wen[a] && !perm.emul;
    assign eraseOk = progOk && perm.blkAny[a];

    always_comb begin
      modeD = MODE_IDLE;
      rejD  = rejQ;
      if (perm.progReq[a] && perm.eraseReq[a]) begin
        rejD = 1'b1;
      end else if (perm.progReq[a]) begin
        if (progOk) begin modeD = MODE_PROG;  rejD = 1'b0; end
        else        rejD = 1'b1;
      end else if (perm.eraseReq[a]) begin
        if (eraseOk) begin modeD = MODE_ERASE; rejD = 1'b0; end
        else         rejD = 1'b1;
      end
    end

    assign violHit[a] = ((modeQ == MODE_PROG) && !progOk) ||
                        ((modeQ == MODE_ERASE) && !eraseOk);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeQ <= MODE_IDLE;
        rejQ  <= 1'b0;
      end else begin
        modeQ <= modeD;
        rejQ  <= rejD;
      end
    end

    assign areaMode[2*a +: 2] = modeQ;
    assign areaReject[a]      = rejQ;

    AST_NO_WEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      !$past(perm.wen[a]) |-> (modeQ == MODE_IDLE)) // R4
      else $error("mode entered without write-enable");
    AST_ERASE_NEEDS_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
      (modeQ == MODE_ERASE) |-> $past(perm.blkAny[a])) // R5
      else $error("erase without an enabled block");
    AST_EMUL_LOCK: assert property (@(posedge clk) disable iff (!rstN)
      $past(perm.emul) |-> (modeQ == MODE_IDLE)) // R7
      else $error("mode entered under emulation lock");
    AST_BOTH_REQ: assert property (@(posedge clk) disable iff (!rstN)
      $past(perm.progReq[a] && perm.eraseReq[a]) |-> (modeQ == MODE_IDLE) && rejQ) // R8
      else $error("conflicting request not refused");
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
      modeQ != 2'd3) // R3
      else $error("illegal mode code");
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         protViol <= 1'b0;
    else if (|violHit) protViol <= 1'b1;
  end

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(protViol) |-> protViol) // R9
    else $error("violation flag cleared");
endmodule

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl
  import flash_prot_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  output logic [2*AREAS-1:0]  areaMode,
  output logic [AREAS-1:0]    areaReject,
  output logic                protViol
);
  localparam int STAT_W = 3 * AREAS + 1;

  strobe_t strb;
  perm_t   perm;

  fp_control i_control (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .perm,
    .strb, .areaMode, .areaReject, .protViol
  );

  fp_datapath #(.STAT_W(STAT_W)) i_datapath (
    .clk, .rstN, .strb, .regAddr,
    .statVec({protViol, areaReject, areaMode}),
    .perm, .regRdata
  );
endmodule

// File: tb/test_flash_prot_ctrl.sv
`timescale 1ns/1ps
module test_flash_prot_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [3:0] areaMode;
  logic [1:0] areaReject;
  logic       protViol;

  flash_prot_ctrl i_flash_prot_ctrl (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string phaseReq = "R1";

  // behavioural reference model
  int mCtrl[2], mBlk[2], mMode[2], mRej[2];
  int mEmul, mViol;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < 2; a++) begin mCtrl[a] = 0; mBlk[a] = 0; mMode[a] = 0; mRej[a] = 0; end
      mEmul = 0; mViol = 0;
    end else begin
      for (int a = 0; a < 2; a++) begin
        bit okP, okE, p, e;
        okP = mCtrl[a][0] && (mEmul == 0);
        okE = okP && (mBlk[a] != 0);
        p = mCtrl[a][1]; e = mCtrl[a][2];
        if ((mMode[a] == 1 && !okP) || (mMode[a] == 2 && !okE)) mViol = 1;
        if (p && e) begin mMode[a] = 0; mRej[a] = 1; end
        else if (p) begin mMode[a] = okP ? 1 : 0; mRej[a] = okP ? 0 : 1; end
        else if (e) begin mMode[a] = okE ? 2 : 0; mRej[a] = okE ? 0 : 1; end
        else mMode[a] = 0;
      end
      if (regWe) begin
        case (regAddr)
          3'd0: mCtrl[0] = regWdata & 8'h07;
          3'd1: mCtrl[1] = regWdata & 8'h07;
          3'd2: mBlk[0]  = regWdata;
          3'd3: mBlk[1]  = regWdata;
          3'd4: mEmul    = regWdata[0];
          default: ;
        endcase
      end
    end
  end

  function automatic int modelRd(input int addr);
    case (addr)
      0: return mCtrl[0];
      1: return mCtrl[1];
      2: return mBlk[0];
      3: return mBlk[1];
      4: return mEmul;
      5: return mMode[0] | (mMode[1] << 2) | (mRej[0] << 4) | (mRej[1] << 5) | (mViol << 6);
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      check(phaseReq, "areaMode lo", int'(areaMode[1:0]), mMode[0]);
      check(phaseReq, "areaMode hi", int'(areaMode[3:2]), mMode[1]);
      check(phaseReq, "areaReject", int'(areaReject), mRej[0] | (mRej[1] << 1));
      check(phaseReq, "protViol", int'(protViol), mViol);
      check(phaseReq, "regRdata", int'(regRdata), modelRd(int'(regAddr)));
    end
  end

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    regWe = 1'b1; regAddr = 3'(addr); regWdata = 8'(data);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); #3;
  endtask

  task automatic rd(input int addr);
    @(negedge clk); regAddr = 3'(addr); #3;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    check("R1", "status at reset", int'(regRdata), 0);
    check("R1", "mode at reset", int'(areaMode), 0);
    rstN = 1'b1;
    rd(5);
    check("R1", "status after reset", int'(regRdata), 0);

    phaseReq = "R2";
    wr(2, 8'hA5); #3;
    check("R2", "blk lo readback", int'(regRdata), 8'hA5);
    wr(5, 8'hFF); #3;
    check("R2", "status write ignored", int'(regRdata), 0);

    phaseReq = "R4";
    wr(0, 8'h02); settle();
    check("R4", "prog without wen", int'(areaMode[1:0]), 0);
    check("R4", "rejected lo", int'(areaReject[0]), 1);
    wr(0, 8'h04); settle();
    check("R4", "erase without wen", int'(areaMode[1:0]), 0);

    phaseReq = "R3";
    wr(0, 8'h03); settle();
    check("R3", "program granted", int'(areaMode[1:0]), 1);
    check("R10", "reject cleared on grant", int'(areaReject[0]), 0);

    phaseReq = "R6";
    wr(2, 8'h00); settle();
    check("R6", "program kept with no blocks", int'(areaMode[1:0]), 1);

    phaseReq = "R5";
    wr(0, 8'h05); settle();
    check("R5", "erase refused, blocks zero", int'(areaMode[1:0]), 0);
    check("R5", "erase rejected flag", int'(areaReject[0]), 1);
    wr(3, 8'hFF); settle();
    check("R5", "upper blocks do not enable lower erase", int'(areaMode[1:0]), 0);
    wr(2, 8'h10); settle();
    check("R5", "erase granted", int'(areaMode[1:0]), 2);

    phaseReq = "R9";
    check("R9", "no violation yet", int'(protViol), 0);
    wr(2, 8'h00); settle();
    check("R9", "erase dropped", int'(areaMode[1:0]), 0);
    check("R9", "violation set", int'(protViol), 1);
    wr(2, 8'h01); rd(5);
    check("R9", "violation sticky", int'(regRdata[6]), 1);

    phaseReq = "R11";
    wr(1, 8'h03); settle();
    check("R11", "upper program alongside lower erase", int'(areaMode), 4'b0110);

    phaseReq = "R7";
    wr(4, 1); settle();
    check("R7", "emulation lock idles both", int'(areaMode), 0);
    check("R7", "both rejected", int'(areaReject), 3);
    wr(4, 0);

    phaseReq = "R8";
    wr(1, 8'h07); settle();
    check("R8", "conflict idle", int'(areaMode[3:2]), 0);
    check("R8", "conflict rejected", int'(areaReject[1]), 1);

    phaseReq = "R10";
    wr(1, 8'h01); settle();
    check("R10", "no request holds reject", int'(areaReject[1]), 1);

    // random phase, model compared every clock
    phaseReq = "R11";
    for (int i = 0; i < 3000; i++) begin
      int addr, data;
      addr = $urandom_range(0, 5);
      data = $urandom_range(0, 255);
      if (addr <= 1) data = data & 7;
      if (addr == 4) data = ($urandom_range(0, 7) == 0) ? 1 : 0;
      if (addr == 2 || addr == 3) data = ($urandom_range(0, 2) == 0) ? 0 : data;
      wr(addr, data);
      regAddr = 3'($urandom_range(0, 5));
      if ($urandom_range(0, 150) == 0) begin
        rstN = 1'b0; @(negedge clk); rstN = 1'b1;
      end
    end

    repeat (3) @(negedge clk);
    #5;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule